// File: doc/BRIEF.md
# Clocked Serial Transceiver with Selectable Clock Source

This block is a synchronous three-wire serial port. Each transfer moves one byte, most significant bit first. The byte goes out on a data-out line while a byte comes in from a data-in line, both timed against a serial clock.

A small control register sets up each transfer:
- a polarity bit, which chooses the idle level of the clock;
- a phase bit, which chooses whether output data leads the first clock edge;
- a three-bit source field, which picks one of seven power-of-two dividers of the system clock (master) or an external clock (slave).

An enable input arms the port. While enable is high, a byte written on the transmit input starts a frame. When the frame ends, the received byte appears on the receive output and a one-cycle completion pulse marks it.

The control register can be changed only while the port is disabled. Dropping enable aborts any frame in flight and parks the shifter, the counters and the divider.

Top module: `syncser_port`

## Requirements
- R1: After reset the control register reads 00H. Its read value is {3'b000, polarity, phase, source[2:0]}, so bits 7 to 5 always read zero.
- R2: A control write while `en` is high leaves the register unchanged. A control write while `en` is low takes effect.
- R3: With source code c in 0..6, the master serial clock toggles every 2^c system cycles. The first toggle comes 2^c cycles after the transmit write is accepted, and the sixteenth toggle comes 16*2^c cycles after it.
- R4: With polarity 0 the serial clock idles high, and with polarity 1 it idles low. `sck_oe` is 1 for source codes 0..6 and 0 for code 7.
- R5: With phase 0, each data-out bit changes on the first clock edge of its bit period and data-in is sampled on the second edge. Bits travel D7 first.
- R6: With phase 1, D7 is on data-out from the start of the frame, before the first edge. Data-in is sampled on the first edge of each bit period and data-out advances on the second edge.
- R7: Source code 7 selects slave mode. The external clock is synchronised through two flops, and its edges drive the same sampling and shifting rules as in master mode.
- R8: After the sixteenth clock edge of a frame, `rx_data` holds the received byte and `done` is high for exactly one cycle. There is one pulse per frame.
- R9: While `en` is low, data-out is 0 and the serial clock sits at its idle level. A frame cut short by dropping `en` produces no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low holds the datapath in reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| tx_we | input | 1 | Transmit byte write; starts a frame |
| tx_data | input | DW | Byte to transmit |
| rx_data | output | DW | Last received byte |
| done | output | 1 | One-cycle frame completion pulse |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sck_i | input | 1 | External serial clock for slave mode |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
Master frames are swept over all seven divider codes and all four polarity/phase combinations. The edge timestamps separate the divider ratios, and the clock level before and after each frame separates the two polarities.

The bench acts as the peer. It drives data-in and samples data-out only on the edges the requirements assign to each phase. A shifter that presents or samples on the wrong edge therefore fails the byte comparisons. Using distinct transmit and receive bytes catches a bit order that is reversed or off by one.

Slave frames run on a slow external clock in all four timing types. Separate cases cover a control write while enabled and a frame aborted by dropping enable.

// File: rtl/syncser_port.sv
module syncser_port #(
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          tx_we,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          done,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          so,
  input  logic          si
);
  localparam int ECW    = $clog2(2*DW);
  localparam int MAXDIV = 2**(2**SELW - 2);
  localparam int HCW    = $clog2(MAXDIV);

  logic [SELW+1:0] ctrl;
  logic            busy, so_r, sck_r;
  logic [HCW-1:0]  hc, lim_m1;
  logic [HCW:0]    lim;
  logic [ECW-1:0]  ec;
  logic [DW-1:0]   txs, rxs;
  logic [2:0]      sy;

  wire pol   = ctrl[SELW+1];
  wire pha   = ctrl[SELW];
  wire slave = &ctrl[SELW-1:0];
  wire sedge = sy[1] ^ sy[2];
  wire last  = ec == ECW'(2*DW-1);
  wire odd   = ec[0];

  assign lim    = (HCW+1)'(1) << ctrl[SELW-1:0];
  assign lim_m1 = HCW'(lim - 1'b1);

  wire tick    = busy & (slave ? sedge : (hc == lim_m1));
  wire present = pha ? (odd & ~last) : ~odd;
  wire sample  = pha ? ~odd : odd;

  assign reg_rdata = {{(8-SELW-2){1'b0}}, ctrl};
  assign sck_o     = sck_r;
  assign sck_oe    = ~slave;
  assign so        = so_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             ctrl <= '0;
    else if (reg_we && !en) ctrl <= reg_wdata[SELW+1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], sck_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; hc <= '0; ec <= '0; txs <= '0; rxs <= '0;
      so_r <= 1'b0; sck_r <= 1'b1; done <= 1'b0; rx_data <= '0;
    end else if (!en) begin
      busy <= 1'b0; hc <= '0; ec <= '0; txs <= '0; rxs <= '0;
      so_r <= 1'b0; sck_r <= ~pol; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck_r <= ~pol;
        if (tx_we) begin
          busy <= 1'b1; hc <= '0; ec <= '0;
          if (pha) begin
            so_r <= tx_data[DW-1];
            txs  <= tx_data << 1;
          end else begin
            txs  <= tx_data;
          end
        end
      end else begin
        if (!slave) hc <= (hc == lim_m1) ? '0 : hc + 1'b1;
        if (tick) begin
          if (!slave) sck_r <= ~sck_r;
          if (present) begin
            so_r <= txs[DW-1];
            txs  <= txs << 1;
          end
          if (sample) rxs <= {rxs[DW-2:0], si};
          ec <= ec + 1'b1;
          if (last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_data <= pha ? rxs : {rxs[DW-2:0], si};
          end
        end
      end
    end
  end
endmodule

// File: rtl/syncser_port_chk.sv
module syncser_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [7:0] reg_rdata,
  input logic       done,
  input logic       sck_o,
  input logic       so
);
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) |-> reg_rdata == $past(reg_rdata)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(en)); // R9

  AST_SO_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !so); // R9

  AST_SCK_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> sck_o != $past(reg_rdata[4])); // R4

  AST_MASTER_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    en && reg_rdata[2:0] != 3'd0 && reg_rdata[2:0] != 3'd7 && !$stable(sck_o)
      |=> $stable(sck_o)); // R3
endmodule

bind syncser_port syncser_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .reg_rdata(reg_rdata),
  .done(done), .sck_o(sck_o), .so(so)
);

// File: tb/tb_syncser_port.sv
`timescale 1ns/1ps
module tb_syncser_port;
  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, reg_we = 1'b0, tx_we = 1'b0;
  logic [7:0] reg_wdata = '0, tx_data = '0, reg_rdata, rx_data;
  logic       done, sck_o, sck_oe, sck_i = 1'b1, so, si = 1'b0;
  int errors = 0, checks = 0, done_cnt = 0;

  always #10 clk = ~clk;
  always @(negedge clk) if (done) done_cnt++;

  syncser_port dut (
    .clk(clk), .rst_n(rst_n), .en(en), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_we(tx_we), .tx_data(tx_data), .rx_data(rx_data),
    .done(done), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .so(so), .si(si)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic master_xfer(input int code, input bit pol, input bit pha,
                             input logic [7:0] tb, input logic [7:0] rb);
    logic [7:0] got;
    int lim, d0;
    time t0, tfirst, tlast;
    lim = 1 << code;
    got = '0;
    @(negedge clk); en = 1'b0;
    wr_ctrl({3'b000, pol, pha, code[2:0]});
    en = 1'b1;
    @(negedge clk);
    chk(sck_o == !pol, "R4 idle level", sck_o, !pol);
    chk(sck_oe == 1'b1, "R4 master drive", sck_oe, 1);
    if (pha) si = rb[7];
    d0 = done_cnt;
    tx_we = 1'b1; tx_data = tb;
    @(negedge clk); tx_we = 1'b0;
    t0 = $time - 10;
    tfirst = 0;
    for (int k = 0; k < 16; k++) begin
      @(sck_o);
      if (k == 0) tfirst = $time;
      tlast = $time;
      #1;
      if (!pha) begin
        if (k % 2 == 0) si = rb[7 - k/2];
        else            got[7 - k/2] = so;
      end else begin
        if (k % 2 == 1) begin
          if (k < 15) si = rb[7 - (k+1)/2];
        end else got[7 - k/2] = so;
      end
    end
    chk(tfirst - t0 == time'(lim*20), "R3 first edge", tfirst - t0, lim*20);
    chk(tlast - t0 == time'(16*lim*20), "R3 frame length", tlast - t0, 16*lim*20);
    repeat (2) @(negedge clk);
    chk(got == tb, pha ? "R6 tx bits" : "R5 tx bits", got, tb);
    chk(rx_data == rb, pha ? "R6 rx byte" : "R5 rx byte", rx_data, rb);
    chk(done_cnt == d0 + 1, "R8 one done pulse", done_cnt - d0, 1);
    chk(sck_o == !pol, "R4 idle after frame", sck_o, !pol);
  endtask

  task automatic slave_xfer(input bit pol, input bit pha,
                            input logic [7:0] tb, input logic [7:0] rb);
    logic [7:0] got;
    int d0;
    got = '0;
    @(negedge clk); en = 1'b0; sck_i = !pol;
    wr_ctrl({3'b000, pol, pha, 3'b111});
    en = 1'b1;
    repeat (6) @(negedge clk);
    chk(sck_oe == 1'b0, "R4 slave no drive", sck_oe, 0);
    if (pha) si = rb[7];
    d0 = done_cnt;
    tx_we = 1'b1; tx_data = tb;
    @(negedge clk); tx_we = 1'b0;
    repeat (5) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      sck_i = ~sck_i;
      if (!pha) begin
        if (k % 2 == 0) si = rb[7 - k/2];
        else            got[7 - k/2] = so;
      end else begin
        if (k % 2 == 1) begin
          if (k < 15) si = rb[7 - (k+1)/2];
        end else got[7 - k/2] = so;
      end
      repeat (5) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(got == tb, "R7 slave tx bits", got, tb);
    chk(rx_data == rb, "R7 slave rx byte", rx_data, rb);
    chk(done_cnt == d0 + 1, "R8 slave done pulse", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
    chk(so == 1'b0, "R9 so at reset", so, 0);
    chk(sck_o == 1'b1, "R4 reset idle high", sck_o, 1);
    chk(done == 1'b0, "R8 done at reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wr_ctrl(8'hFF);
    chk(reg_rdata == 8'h1F, "R1 upper bits zero", reg_rdata, 8'h1F);
    wr_ctrl(8'h0A);
    chk(reg_rdata == 8'h0A, "R2 write while disabled", reg_rdata, 8'h0A);
    en = 1'b1;
    wr_ctrl(8'h15);
    chk(reg_rdata == 8'h0A, "R2 write while enabled", reg_rdata, 8'h0A);
    en = 1'b0;

    for (int c = 0; c < 7; c++)
      for (int t = 0; t < 4; t++) begin
        logic [7:0] a, b;
        a = 8'(8'h3C ^ (c*37 + t*11));
        b = 8'(~a ^ 8'h5A ^ (t << 4));
        master_xfer(c, t[1], t[0], a, b);
      end

    for (int t = 0; t < 4; t++) slave_xfer(t[1], t[0], 8'(8'hC3 + t*29), 8'(8'h81 ^ (t*19)));

    begin
      int d0;
      master_xfer(0, 1'b1, 1'b0, 8'hFF, 8'hFF);
      @(negedge clk); en = 1'b0;
      wr_ctrl(8'h03);
      en = 1'b1;
      d0 = done_cnt;
      @(negedge clk); tx_we = 1'b1; tx_data = 8'hFF;
      @(negedge clk); tx_we = 1'b0;
      repeat (40) @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
      chk(so == 1'b0, "R9 so low when disabled", so, 0);
      chk(sck_o == 1'b1, "R9 clock idles when disabled", sck_o, 1);
      repeat (200) @(negedge clk);
      chk(done_cnt == d0, "R9 abort gives no done", done_cnt - d0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule